// File: doc/BRIEF.md
# Receive Status Deferral Watchdog

This block works next to a receive DMA engine and decides when the sticky receive-complete status bit is raised. A frame whose descriptor asks for status on completion raises the bit at once. A frame whose descriptor suppresses that status arms a timeout instead. When the timeout runs out, the bit is raised for all the quiet frames that came before. In this way, several quiet completions are merged into one status event, while the status still arrives within a bounded delay.

The timeout is counted in ticks of an internal free-running prescaler that fires once every `PRESCALE` clocks. The timer is loaded from a programmed count, and a count of zero turns the mechanism off. If a later frame completes with its status enabled, that frame sets the bit directly and cancels a pending timeout. Software clears the bit by pulsing a write-1-to-clear strobe. The interrupt output is the status bit gated by the receive interrupt enable.

The block carries no data stream, so it has no valid/ready interface. All pins are plain single-cycle controls or levels.

Top module: `rx_stat_wdog`

## Requirements
- R1: After reset, `rx_status` and `rx_irq` are both 0 and no timeout is pending.
- R2: When `wdt_load` is 0, a completion with `desc_stat_en`=0 never sets `rx_status` by itself.
- R3: With `wdt_load`=N (N>0) and no timeout pending, a completion with `desc_stat_en`=0 arms the timer with N. `rx_status` rises in the cycle after the edge that sees the N-th prescaler tick following the arming edge.
- R4: `rx_irq` is high exactly when `rx_status` is 1 and `rx_irq_en` is 1. An expiry with the enable low sets the status bit only.
- R5: A completion with `desc_stat_en`=1 sets `rx_status` on the next edge and disarms any pending timeout, so that timeout never fires.
- R6: A completion with `desc_stat_en`=0 while a timeout is pending neither reloads nor extends it.
- R7: `rx_status` is sticky. A `sts_clr` pulse clears it on the next edge, unless a set event occurs in the same cycle, in which case the bit ends up 1.
- R8: A change of `wdt_load` while a timeout is pending does not alter that timeout; the new value is used at the next arming.
- R9: The prescaler ticks once every `PRESCALE` clocks, the first tick coming `PRESCALE` clocks after reset is released, and only ticks advance the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle pulse: a received frame finished transfer to memory |
| desc_stat_en | input | 1 | Descriptor asks for status on completion; qualifies `frame_done` |
| wdt_load | input | WDT_W | Programmed timeout in prescaler ticks; 0 disables |
| rx_irq_en | input | 1 | Receive interrupt enable |
| sts_clr | input | 1 | Write-1-to-clear strobe for the status bit |
| rx_status | output | 1 | Sticky receive status bit |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `frame_done` and `sts_clr` are synchronous and are sampled only at clock edges. `desc_stat_en` only has meaning while `frame_done` is high. `wdt_load` may change at any edge. The bench drives every input just after a falling edge and holds it through the next rising edge. Random stimulus keeps `wdt_load` small, so that timeouts expire within the run. It also mixes frames, clears and enable changes at rates that produce overlaps: a cancel during a pending timeout, and a clear in the same cycle as a set.

// File: rtl/rx_stat_wdog_pkg.sv
package rx_stat_wdog_pkg;
  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;
endpackage

// File: rtl/rx_stat_prescaler.sv
module rx_stat_prescaler #(
  parameter int PRESCALE = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PS_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);

      // ticks are isolated when dividing by more than one
      p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rx_stat_timer.sv
module rx_stat_timer
  import rx_stat_wdog_pkg::*;
#(
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm_req,
  input  logic             cancel,
  input  logic [WDT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [WDT_W-1:0] ONE = WDT_W'(1);

  wd_state_e        st_q;
  logic [WDT_W-1:0] rem_q;
  logic             start;

  assign start  = arm_req && (load_val != '0) && (st_q == WD_IDLE) && !cancel;
  assign expire = (st_q == WD_RUN) && tick && (rem_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WD_IDLE;
      rem_q <= '0;
    end else if (cancel) begin
      st_q  <= WD_IDLE;
    end else if (start) begin
      st_q  <= WD_RUN;
      rem_q <= load_val;
    end else if (st_q == WD_RUN && tick) begin
      if (rem_q == ONE) st_q <= WD_IDLE;
      else              rem_q <= rem_q - 1'b1;
    end
  end

  p_cancel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (st_q == WD_IDLE));
  p_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WD_IDLE && load_val == '0) |=> (st_q == WD_IDLE));
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WD_RUN && !tick && !cancel) |=> (st_q == WD_RUN && rem_q == $past(rem_q)));
  p_load_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WD_RUN && tick && !cancel && rem_q != ONE) |=> (rem_q == $past(rem_q) - 1'b1));
  p_rem_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WD_RUN) |-> (rem_q != '0));
endmodule

// File: rtl/rx_stat_flag.sv
module rx_stat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag && !clr) || set_evt;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/rx_stat_wdog.sv
module rx_stat_wdog #(
  parameter int WDT_W    = 8,
  parameter int PRESCALE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             desc_stat_en,
  input  logic [WDT_W-1:0] wdt_load,
  input  logic             rx_irq_en,
  input  logic             sts_clr,
  output logic             rx_status,
  output logic             rx_irq
);
  logic tick, expire, direct_set, quiet_done;

  assign direct_set = frame_done && desc_stat_en;
  assign quiet_done = frame_done && !desc_stat_en;

  rx_stat_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rx_stat_timer #(.WDT_W(WDT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm_req(quiet_done),
    .cancel(direct_set), .load_val(wdt_load), .expire(expire)
  );

  rx_stat_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(direct_set || expire),
    .clr(sts_clr), .flag(rx_status)
  );

  assign rx_irq = rx_status && rx_irq_en;

  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    direct_set |=> rx_status);
  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq_en |-> !rx_irq);
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_status && !direct_set && !expire) |=> !rx_status);
  p_expire_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);
endmodule

// File: tb/rx_stat_wdog_tb.sv
module rx_stat_wdog_tb_top;
  localparam int W = 8;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_done = 1'b0, desc_stat_en = 1'b0, rx_irq_en = 1'b0, sts_clr = 1'b0;
  logic [W-1:0] wdt_load = '0;
  logic rx_status, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  int  m_ps;
  bit  m_act;
  int  m_rem;
  bit  m_stat;

  always #5 clk = ~clk;

  rx_stat_wdog #(.WDT_W(W), .PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .desc_stat_en(desc_stat_en),
    .wdt_load(wdt_load), .rx_irq_en(rx_irq_en), .sts_clr(sts_clr),
    .rx_status(rx_status), .rx_irq(rx_irq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive inputs after a falling edge, advance model, compare at next falling edge
  task automatic step(input bit fd, input bit se, input int ld, input bit en,
                      input bit clr, input string tag);
    bit tk, cancel, start, expire;
    frame_done = fd; desc_stat_en = se; wdt_load = W'(ld); rx_irq_en = en; sts_clr = clr;
    tk     = (m_ps == P - 1);
    cancel = fd && se;
    start  = fd && !se && (ld != 0) && !m_act;
    expire = m_act && tk && (m_rem == 1);
    m_stat = (m_stat && !clr) || cancel || expire;
    if (cancel) m_act = 1'b0;
    else if (start) begin m_act = 1'b1; m_rem = ld; end
    else if (m_act && tk) begin
      if (m_rem == 1) m_act = 1'b0; else m_rem = m_rem - 1;
    end
    m_ps = tk ? 0 : m_ps + 1;
    @(negedge clk);
    check({tag, " status"}, rx_status, m_stat);
    check({"R4 irq/", tag}, rx_irq, m_stat && en);
  endtask

  task automatic idle(input int n, input int ld, input bit en, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, ld, en, 0, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    m_ps = 0; m_act = 0; m_rem = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    check("R1 reset status", rx_status, 1'b0);
    check("R1 reset irq", rx_irq, 1'b0);
    rst_n = 1'b1;

    // R2: zero load disables
    step(1, 0, 0, 1, 0, "R2");
    idle(40, 0, 1, "R2");
    check("R2 still clear", rx_status, 1'b0);

    // R3/R9: arm with 3 ticks, enable low so irq stays low
    step(1, 0, 3, 0, 0, "R3");
    idle(16, 3, 0, "R9");
    check("R3 expired", rx_status, 1'b1);
    check("R4 masked irq", rx_irq, 1'b0);
    step(0, 0, 3, 1, 0, "R4");
    check("R4 irq on", rx_irq, 1'b1);
    step(0, 0, 3, 1, 1, "R7");
    check("R7 cleared", rx_status, 1'b0);

    // R5: cancel pending timeout
    step(1, 0, 5, 1, 0, "R5");
    idle(2, 5, 1, "R5");
    step(1, 1, 5, 1, 0, "R5");
    check("R5 direct set", rx_status, 1'b1);
    step(0, 0, 5, 1, 1, "R5");
    idle(40, 5, 1, "R5");
    check("R5 no late fire", rx_status, 1'b0);

    // R6: second quiet frame does not restart
    step(1, 0, 3, 1, 0, "R6");
    idle(6, 3, 1, "R6");
    step(1, 0, 3, 1, 0, "R6");
    idle(12, 3, 1, "R6");
    step(0, 0, 3, 1, 1, "R6");

    // R8: reload while running
    step(1, 0, 4, 1, 0, "R8");
    idle(5, 1, 1, "R8");
    idle(20, 1, 1, "R8");
    step(0, 0, 1, 1, 1, "R8");
    step(1, 0, 1, 1, 0, "R8");
    idle(8, 1, 1, "R8");

    // R7: set and clear together
    step(1, 1, 0, 1, 1, "R7");
    check("R7 set wins", rx_status, 1'b1);
    step(0, 0, 0, 1, 1, "R7");

    // random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 8) == 0, $urandom % 2, $urandom % 6, $urandom % 2,
           ($urandom % 16) == 0, "R3/R5/R7 rand");
    end

    finished = 1'b1;
    summary();
  end
endmodule